// File: doc/BRIEF.md
# Inverted-Polarity PWM Timer with Register Port

This block is a single-channel pulse-width timer that a processor programs through a small memory-mapped register port shaped like APB. An up-counter runs on the bus clock. Two 32-bit compare values are held in registers: one sets where the cycle wraps (the period) and one sets where the output turns on inside the cycle (the duty point). A control register holds three bits. One starts and stops counting, one lets the waveform reach the pin, and one holds the counter at zero.

The output is inverted: each cycle starts low, goes high when the counter reaches the duty point, and returns low at the period. Software typically clears the control register, sets the clear bit, loads both compare values, and then writes run plus drive. Writing zero to the control register stops the waveform, and the pin goes low in the cycle that follows the write.

Top module: `pwm_timer`

## Requirements
- R1: After the asynchronous active-low reset, the duty, period and control registers and the counter are all zero, and the pin is low.
- R2: A write takes effect at the clock edge where psel, penable and pwrite are all high. The duty register is at byte offset 0x4, the period register at 0x8 and the control register at 0xC. While psel is high, prdata shows the addressed register combinationally. While psel is low, prdata is zero.
- R3: Only control bits 0 (run), 3 (drive) and 7 (clear) are stored, and the other control bits read as zero. Any offset other than 0x4, 0x8 and 0xC reads as zero, and writes to such an offset change nothing.
- R4: When run is 1 and clear is 0, the counter advances by one on each clock. On the clock after it reaches or passes the period value, it returns to zero.
- R5: When run is 0 and clear is 0, the counter keeps its value, and counting resumes from that value when run is set again.
- R6: While clear is 1, the counter is held at zero whatever run is.
- R7: When run and drive are both 1, the pin is high exactly when the counter is at or above the duty value and below the period value. The pin is low otherwise.
- R8: A duty value at or above the period value keeps the pin low for the whole cycle.
- R9: The pin is low whenever run or drive is 0. A write that clears run drives the pin low right after that write edge, without waiting for the period to end.
- R10: Both compare values cover 0 to 2^32-1. A period of 0 gives a constant low pin. A period of 1 with a duty of 0 toggles the pin every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; also clocks the counter |
| rstN | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase qualifier |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 4 | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pwmOut | output | 1 | Inverted PWM pin |

## Verification
A counter that steps, wraps or holds wrongly shows up at the pin as a shifted rising or falling edge. This appears within one programmed period, so the bench compares the pin with its model on every clock. A fault in the gating logic shows in the first cycle after the control write that should have forced the pin low. A register bit that is stored or decoded wrongly shows up on the very next read of that offset.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  // Byte offsets of the registers
  localparam int unsigned DUTY_OFF   = 4;
  localparam int unsigned PERIOD_OFF = 8;
  localparam int unsigned CTRL_OFF   = 12;
  // Control bit positions
  localparam int unsigned RUN_BIT    = 0;
  localparam int unsigned DRIVE_BIT  = 3;
  localparam int unsigned CLEAR_BIT  = 7;

  // Strobes passed from the register block to the datapath
  typedef struct packed {
    logic run;
    logic drive;
    logic clear;
  } pwmStrb_t;
endpackage

// File: rtl/pwm_timer_regs.sv
module pwm_timer_regs
  import pwm_timer_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic [DATA_W-1:0] dutyVal,
  output logic [DATA_W-1:0] periodVal,
  output pwmStrb_t          strb
);
  localparam logic [ADDR_W-1:0] DUTY_A   = ADDR_W'(DUTY_OFF);
  localparam logic [ADDR_W-1:0] PERIOD_A = ADDR_W'(PERIOD_OFF);
  localparam logic [ADDR_W-1:0] CTRL_A   = ADDR_W'(CTRL_OFF);
  localparam logic [DATA_W-1:0] CTRL_MASK =
    (DATA_W'(1) << RUN_BIT) | (DATA_W'(1) << DRIVE_BIT) | (DATA_W'(1) << CLEAR_BIT);

  logic wrEn, hitDuty, hitPeriod, hitCtrl;
  logic runQ, driveQ, clearQ;
  logic [DATA_W-1:0] ctrlView;

  assign wrEn      = psel & penable & pwrite;
  assign hitDuty   = (paddr == DUTY_A);
  assign hitPeriod = (paddr == PERIOD_A);
  assign hitCtrl   = (paddr == CTRL_A);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dutyVal   <= '0;
      periodVal <= '0;
      runQ      <= 1'b0;
      driveQ    <= 1'b0;
      clearQ    <= 1'b0;
    end else if (wrEn) begin
      if (hitDuty)   dutyVal   <= pwdata;
      if (hitPeriod) periodVal <= pwdata;
      if (hitCtrl) begin
        runQ   <= pwdata[RUN_BIT];
        driveQ <= pwdata[DRIVE_BIT];
        clearQ <= pwdata[CLEAR_BIT];
      end
    end
  end

  always_comb begin
    ctrlView            = '0;
    ctrlView[RUN_BIT]   = runQ;
    ctrlView[DRIVE_BIT] = driveQ;
    ctrlView[CLEAR_BIT] = clearQ;
  end

  always_comb begin
    prdata = '0;
    if (psel) begin
      if (hitDuty)        prdata = dutyVal;
      else if (hitPeriod) prdata = periodVal;
      else if (hitCtrl)   prdata = ctrlView;
    end
  end

  assign strb.run   = runQ;
  assign strb.drive = driveQ;
  assign strb.clear = clearQ;

  // R2: a duty write lands at its access edge
  p_duty_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && hitDuty) |=> (dutyVal == $past(pwdata)));
  // R2: a period write lands at its access edge
  p_period_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && hitPeriod) |=> (periodVal == $past(pwdata)));
  // R3: unused control bits never read back as one
  p_ctrl_unused_r3: assert property (@(posedge clk) disable iff (!rstN)
    (psel && hitCtrl) |-> ((prdata & ~CTRL_MASK) == '0));
  // R3: writes elsewhere leave the stored registers alone
  p_unmapped_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !hitDuty && !hitPeriod && !hitCtrl) |=>
      ($stable(dutyVal) && $stable(periodVal) && $stable(strb)));
endmodule

// File: rtl/pwm_timer_core.sv
module pwm_timer_core
  import pwm_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  pwmStrb_t         strb,
  input  logic [CNT_W-1:0] dutyVal,
  input  logic [CNT_W-1:0] periodVal,
  output logic             pwmOut
);
  logic [CNT_W-1:0] cnt;
  logic atEnd, inWindow;

  assign atEnd    = (cnt >= periodVal);
  assign inWindow = (cnt >= dutyVal) && (cnt < periodVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cnt <= '0;
    else if (strb.clear) cnt <= '0;
    else if (strb.run)   cnt <= atEnd ? '0 : cnt + 1'b1;
  end

  assign pwmOut = strb.run & strb.drive & inWindow;

  // R4: step by one inside the cycle
  p_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !strb.clear && cnt < periodVal) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
  // R4: wrap to zero after the period value
  p_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !strb.clear && cnt >= periodVal) |=> (cnt == '0));
  // R5: hold while stopped
  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.run && !strb.clear) |=> $stable(cnt));
  // R6: clear pins the counter at zero
  p_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (cnt == '0));
  // R8: duty at or past period keeps the pin low
  p_no_window_r8: assert property (@(posedge clk) disable iff (!rstN)
    (dutyVal >= periodVal) |-> !pwmOut);
  // R9: gating forces the pin low
  p_gate_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.run && strb.drive) |-> !pwmOut);
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pwmOut
);
  pwmStrb_t          strb;
  logic [DATA_W-1:0] dutyVal, periodVal;

  pwm_timer_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .dutyVal(dutyVal), .periodVal(periodVal), .strb(strb)
  );

  pwm_timer_core #(.CNT_W(DATA_W)) u_core (
    .clk(clk), .rstN(rstN), .strb(strb),
    .dutyVal(dutyVal), .periodVal(periodVal), .pwmOut(pwmOut)
  );

  // R1: pin is low in the first cycles after reset
  p_reset_low_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !pwmOut);
endmodule

// File: tb/pwm_timer_tb.sv
`timescale 1ns/1ps
module pwm_timer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [3:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pwmOut;

  int nCmp = 0;
  int nBad = 0;
  string curTag = "R1";
  bit done = 0;

  // behavioural model state
  logic [31:0] mDuty = 0, mPer = 0, mCnt = 0;
  bit mRun = 0, mDrv = 0, mClr = 0;

  always #10 clk = ~clk;

  pwm_timer u_dut (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pwmOut(pwmOut)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mDuty = 0; mPer = 0; mCnt = 0; mRun = 0; mDrv = 0; mClr = 0;
    end else begin
      if (mClr) mCnt = 0;
      else if (mRun) mCnt = (mCnt >= mPer) ? 32'd0 : mCnt + 32'd1;
      if (psel && penable && pwrite) begin
        case (paddr)
          4'h4: mDuty = pwdata;
          4'h8: mPer = pwdata;
          4'hC: begin mRun = pwdata[0]; mDrv = pwdata[3]; mClr = pwdata[7]; end
          default: ;
        endcase
      end
    end
  end

  function automatic bit expPin();
    return mRun && mDrv && (mCnt >= mDuty) && (mCnt < mPer);
  endfunction

  // per-cycle pin comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      nCmp++;
      if (pwmOut !== expPin()) begin
        nBad++;
        $display("FAIL %s pin: actual %0b expected %0b (t=%0t)", curTag, pwmOut, expPin(), $time);
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(string tag, logic [3:0] a, logic [31:0] exp);
    @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = a;
    #1 chk(tag, prdata, exp);
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    nBad++;
    $display("FAIL watchdog: actual timeout expected finish");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    #35 rstN = 1;
    // R1: reset state
    curTag = "R1";
    rd("R1 duty", 4'h4, 0); rd("R1 period", 4'h8, 0); rd("R1 ctrl", 4'hC, 0);
    chk("R1 pin", {31'b0, pwmOut}, 0);

    // R2: register map and readback; prdata zero when not selected
    curTag = "R2";
    wr(4'h4, 32'h1234_5678); wr(4'h8, 32'hCAFE_F00D);
    rd("R2 duty", 4'h4, 32'h1234_5678); rd("R2 period", 4'h8, 32'hCAFE_F00D);
    #1 chk("R2 idle prdata", prdata, 0);

    // R3: control keeps bits 0,3,7 only; unmapped offsets read zero, writes ignored
    curTag = "R3";
    wr(4'hC, 32'hFFFF_FFFF); rd("R3 ctrl", 4'hC, 32'h0000_0089);
    wr(4'hC, 0);
    wr(4'h0, 32'hDEAD_BEEF); rd("R3 off0", 4'h0, 0); rd("R3 off2", 4'h2, 0);
    rd("R3 duty kept", 4'h4, 32'h1234_5678);

    // R4/R7: normal running, duty 3 period 9
    curTag = "R7";
    wr(4'hC, 32'h80); wr(4'h4, 3); wr(4'h8, 9); wr(4'hC, 32'h09);
    idle(30);
    curTag = "R4"; idle(12);

    // R5: stop, hold, resume
    curTag = "R5";
    wr(4'hC, 32'h08); idle(7); wr(4'hC, 32'h09); idle(20);

    // R6: clear holds counter at zero
    curTag = "R6";
    wr(4'hC, 32'h89); idle(10); wr(4'hC, 32'h09); idle(15);

    // R8: duty above and equal to period
    curTag = "R8";
    wr(4'h4, 12); idle(25); wr(4'h4, 9); idle(25);

    // R9: drive off keeps pin low; clearing run drops the pin at once
    curTag = "R9";
    wr(4'h4, 2); wr(4'hC, 32'h01); idle(15); wr(4'hC, 32'h09);
    while (pwmOut !== 1'b1) @(negedge clk);
    wr(4'hC, 0);
    chk("R9 pin low after stop", {31'b0, pwmOut}, 0);
    idle(5);

    // R10: extreme compare values
    curTag = "R10";
    wr(4'hC, 32'h80); wr(4'h8, 0); wr(4'h4, 0); wr(4'hC, 32'h09); idle(10);
    wr(4'h8, 1); idle(12);
    wr(4'h4, 32'hFFFF_FFFF); wr(4'h8, 32'hFFFF_FFFF); idle(10);
    rd("R10 period max", 4'h8, 32'hFFFF_FFFF);
    wr(4'h4, 0); idle(5);
    chk("R10 pin high long period", {31'b0, pwmOut}, 1);
    rd("R10 duty zero", 4'h4, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule